// File: doc/BRIEF.md
# Mode-Banked Special Register File

This block keeps the special-purpose state of a small core that runs in one of three privilege levels: user, supervisor and fault. It holds a link register and a program counter and stack pointer for each level. Two alias indices always reach the counter or pointer of the level that is running now. It also holds a status word, made of four ALU condition flags and a one-hot level field, and one exception record for each of the two privileged levels. Software reaches every register through one read port and one write port, each addressed by a 4-bit index. Each access is checked against the running level.

Two hardware ports sit beside the software ports. The ALU uses the flag port to update the condition flags. The trap port moves the core to another level. When the target is a privileged level, the trap port also writes the exception record of that level. A user-level access to a register that is reserved for the privileged levels is refused. The register keeps its value, a read returns zero, and a one-cycle violation pulse follows on the next clock.

Top module: `mbank_sreg_file`

## Requirements
- R1: After reset the running level is supervisor. The status word (index 9) reads 0x0000_0200, and every other index (0 to 8, 10, 11) reads zero.
- R2: Status word layout: C is bit 0, Z bit 1, N bit 2, V bit 3, U bit 8, S bit 9, F bit 10. All other bits read as zero. A privileged write to index 9 changes only bits 3:0, so writing 0xFFFF_FFFF in supervisor reads back 0x0000_020F.
- R3: In user level a write to index 9 is dropped without a violation pulse, and the status word stays readable.
- R4: A pulse on alu_flag_we loads alu_flags[3:0] into {V,N,Z,C} on the next clock, in every level.
- R5: When a write that is allowed to reach index 9 and the flag port act in the same cycle, the software value sets C, Z, N and V. A user write that is dropped does not block the flag port.
- R6: Index 1 (PC_CUR) and index 2 (SP_CUR) read and write the program counter and stack pointer of the running level. The banks of the other levels are left unchanged.
- R7: Index 0 (LINK), 3 (PC_USR) and 4 (SP_USR) can be read and written in all three levels.
- R8: In user level, an access to index 5 to 8 (PC_SUP, SP_SUP, PC_FLT, SP_FLT) or to index 10 or 11 (XREC_SUP, XREC_FLT) is refused. A refused read returns zero, and a refused write leaves the register unchanged. priv_viol goes high for exactly the cycle after such an access, and stays low after any other access.
- R9: trap_mode selects the target level: 0 is user, 1 is supervisor, 2 is fault, and 3 is ignored. A trap to supervisor or fault loads that level's record as {trap_id in bits 31:24, trap_arg in bits 23:0}. From the next cycle the level field shows only the target level.
- R10: Writes to index 10 and 11 are ignored in every level. In supervisor and fault they raise no violation.
- R11: cur_mode (bit 0 U, bit 1 S, bit 2 F) always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read access strobe |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 32 | Read value, combinational from rd_idx |
| wr_en | input | 1 | Write access strobe |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write value |
| alu_flag_we | input | 1 | Flag update from the ALU |
| alu_flags | input | 4 | New {V,N,Z,C} |
| trap_en | input | 1 | Level change / exception entry |
| trap_mode | input | 2 | Target level code |
| trap_id | input | 8 | Exception identifier |
| trap_arg | input | 24 | Exception argument |
| cur_mode | output | 3 | One-hot running level {F,S,U} |
| priv_viol | output | 1 | Privilege violation pulse |

## Verification
The bench changes level so that each alias index lands on all three banks. If the aliases were wired to a fixed bank, a write through SP_CUR in fault level would appear in the supervisor pointer. It drives a software status write and a flag update in the same cycle, both from supervisor and from user. A wrong priority, or a dropped user write that still blocks the ALU, shows up in the read-back flags. The bench also makes refused user reads and writes, then checks from supervisor that the target register kept its value and that the violation pulse lasted one cycle. Finally it checks that a record write does nothing and that the invalid trap code leaves the level field as it was.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam int NUM_MODES = 3;
   localparam int BSEL_W    = 2;

   // Level codes, also the bank numbers.
   localparam logic [BSEL_W-1:0] LVL_USR = 2'd0;
   localparam logic [BSEL_W-1:0] LVL_SUP = 2'd1;
   localparam logic [BSEL_W-1:0] LVL_FLT = 2'd2;

   typedef enum logic [3:0] {
      SR_LINK     = 4'd0,
      SR_PC_CUR   = 4'd1,
      SR_SP_CUR   = 4'd2,
      SR_PC_USR   = 4'd3,
      SR_SP_USR   = 4'd4,
      SR_PC_SUP   = 4'd5,
      SR_SP_SUP   = 4'd6,
      SR_PC_FLT   = 4'd7,
      SR_SP_FLT   = 4'd8,
      SR_STAT     = 4'd9,
      SR_XREC_SUP = 4'd10,
      SR_XREC_FLT = 4'd11
   } sreg_idx_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_LINK,
      K_PC,
      K_SP,
      K_STAT,
      K_XREC
   } sreg_kind_e;

endpackage

// File: rtl/sreg_access_ctrl.sv
module sreg_access_ctrl
   import sreg_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0]     idx,
   input  logic [NUM_MODES-1:0] mode_oh,
   output sreg_kind_e           kind,
   output logic [BSEL_W-1:0]    bank,
   output logic                 writable,
   output logic                 denied
);

   logic              user_lvl;
   logic [BSEL_W-1:0] cur_bank;
   logic              hi_zero;
   logic [3:0]        lo_idx;

   assign user_lvl = mode_oh[0];
   assign cur_bank = mode_oh[2] ? LVL_FLT : (mode_oh[1] ? LVL_SUP : LVL_USR);
   assign lo_idx   = idx[3:0];

   generate
      if (IDX_W > 4) begin : g_wide
         assign hi_zero = (idx[IDX_W-1:4] == '0);
      end else begin : g_narrow
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      kind     = K_NONE;
      bank     = LVL_USR;
      writable = 1'b0;
      denied   = 1'b0;
      if (hi_zero) begin
         case (sreg_idx_e'(lo_idx))
            SR_LINK:     begin kind = K_LINK; writable = 1'b1; end
            SR_PC_CUR:   begin kind = K_PC; bank = cur_bank; writable = 1'b1; end
            SR_SP_CUR:   begin kind = K_SP; bank = cur_bank; writable = 1'b1; end
            SR_PC_USR:   begin kind = K_PC; bank = LVL_USR;  writable = 1'b1; end
            SR_SP_USR:   begin kind = K_SP; bank = LVL_USR;  writable = 1'b1; end
            SR_PC_SUP:   begin kind = K_PC; bank = LVL_SUP;  writable = 1'b1; denied = user_lvl; end
            SR_SP_SUP:   begin kind = K_SP; bank = LVL_SUP;  writable = 1'b1; denied = user_lvl; end
            SR_PC_FLT:   begin kind = K_PC; bank = LVL_FLT;  writable = 1'b1; denied = user_lvl; end
            SR_SP_FLT:   begin kind = K_SP; bank = LVL_FLT;  writable = 1'b1; denied = user_lvl; end
            SR_STAT:     begin kind = K_STAT; writable = !user_lvl; end
            SR_XREC_SUP: begin kind = K_XREC; bank = LVL_SUP; denied = user_lvl; end
            SR_XREC_FLT: begin kind = K_XREC; bank = LVL_FLT; denied = user_lvl; end
            default:     kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
   import sreg_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             link_we,
   input  logic                             pc_we,
   input  logic                             sp_we,
   input  logic [BSEL_W-1:0]                wsel,
   input  logic [XLEN-1:0]                  wdata,
   output logic [XLEN-1:0]                  link_q,
   output logic [NUM_MODES-1:0][XLEN-1:0]   pc_q,
   output logic [NUM_MODES-1:0][XLEN-1:0]   sp_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       link_q <= '0;
      else if (link_we) link_q <= wdata;
   end

   for (genvar b = 0; b < NUM_MODES; b++) begin : g_lvl
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pc_q[b] <= '0;
            sp_q[b] <= '0;
         end else begin
            if (pc_we && wsel == BSEL_W'(b)) pc_q[b] <= wdata;
            if (sp_we && wsel == BSEL_W'(b)) sp_q[b] <= wdata;
         end
      end
   end

endmodule

// File: rtl/sreg_status.sv
module sreg_status
   import sreg_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NUM_FLAGS = 4,
   parameter int XID_W     = 8,
   parameter int XARG_W    = 24
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           sw_we,
   input  logic [NUM_FLAGS-1:0]           sw_flags,
   input  logic                           alu_we,
   input  logic [NUM_FLAGS-1:0]           alu_flags,
   input  logic                           trap_en,
   input  logic [BSEL_W-1:0]              trap_mode,
   input  logic [XID_W-1:0]               trap_id,
   input  logic [XARG_W-1:0]              trap_arg,
   output logic [XLEN-1:0]                stat_word,
   output logic [NUM_MODES-1:0]           mode_oh,
   output logic [NUM_MODES-1:0][XLEN-1:0] xrec_q
);

   localparam int FLAG_LSB = 0;
   localparam int MODE_LSB = 8;

   logic [NUM_FLAGS-1:0] flags_q;
   logic                 trap_ok;

   assign trap_ok = trap_en && (trap_mode < BSEL_W'(NUM_MODES));

   // Software value has priority over the ALU.
   always_ff @(posedge clk) begin
      if (!rst_n)      flags_q <= '0;
      else if (sw_we)  flags_q <= sw_flags;
      else if (alu_we) flags_q <= alu_flags;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_oh <= NUM_MODES'(1) << LVL_SUP;
      else if (trap_ok) mode_oh <= NUM_MODES'(1) << trap_mode;
   end

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_xrec
      if (m == 0) begin : g_none
         assign xrec_q[m] = '0;
      end else begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               xrec_q[m] <= '0;
            else if (trap_ok && trap_mode == BSEL_W'(m))
               xrec_q[m] <= {trap_id, trap_arg};
         end
      end
   end

   always_comb begin
      stat_word = '0;
      stat_word[FLAG_LSB +: NUM_FLAGS] = flags_q;
      stat_word[MODE_LSB +: NUM_MODES] = mode_oh;
   end

endmodule

// File: rtl/mbank_sreg_file.sv
module mbank_sreg_file
   import sreg_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IDX_W     = 4,
   parameter int NUM_FLAGS = 4,
   parameter int XID_W     = 8,
   parameter int XARG_W    = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [XLEN-1:0]      rd_data,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [XLEN-1:0]      wr_data,
   input  logic                 alu_flag_we,
   input  logic [NUM_FLAGS-1:0] alu_flags,
   input  logic                 trap_en,
   input  logic [1:0]           trap_mode,
   input  logic [XID_W-1:0]     trap_id,
   input  logic [XARG_W-1:0]    trap_arg,
   output logic [NUM_MODES-1:0] cur_mode,
   output logic                 priv_viol
);

   generate
      if (XID_W + XARG_W != XLEN) begin : g_bad_rec
         $error("exception record fields must fill XLEN");
      end
      if (XLEN < 11 || NUM_FLAGS != 4) begin : g_bad_stat
         $error("status word needs XLEN >= 11 and four flags");
      end
      if (IDX_W < 4) begin : g_bad_idx
         $error("IDX_W must be at least 4");
      end
   endgenerate

   sreg_kind_e        rk, wk;
   logic [BSEL_W-1:0] rbank, wbank;
   logic              rwr_unused, r_denied;
   logic              w_ok_kind, w_denied;
   logic              w_go;

   logic [XLEN-1:0]                  link_q;
   logic [NUM_MODES-1:0][XLEN-1:0]   pc_q, sp_q, xrec_q;
   logic [XLEN-1:0]                  psr_w;
   logic [NUM_MODES-1:0]             mode_oh;

   sreg_access_ctrl #(.IDX_W(IDX_W)) u_rd_ctrl (
      .idx(rd_idx), .mode_oh(mode_oh), .kind(rk), .bank(rbank),
      .writable(rwr_unused), .denied(r_denied)
   );

   sreg_access_ctrl #(.IDX_W(IDX_W)) u_wr_ctrl (
      .idx(wr_idx), .mode_oh(mode_oh), .kind(wk), .bank(wbank),
      .writable(w_ok_kind), .denied(w_denied)
   );

   assign w_go = wr_en && w_ok_kind && !w_denied;

   sreg_bank #(.XLEN(XLEN)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .link_we(w_go && wk == K_LINK),
      .pc_we(w_go && wk == K_PC),
      .sp_we(w_go && wk == K_SP),
      .wsel(wbank), .wdata(wr_data),
      .link_q(link_q), .pc_q(pc_q), .sp_q(sp_q)
   );

   sreg_status #(
      .XLEN(XLEN), .NUM_FLAGS(NUM_FLAGS), .XID_W(XID_W), .XARG_W(XARG_W)
   ) u_stat (
      .clk(clk), .rst_n(rst_n),
      .sw_we(w_go && wk == K_STAT), .sw_flags(wr_data[NUM_FLAGS-1:0]),
      .alu_we(alu_flag_we), .alu_flags(alu_flags),
      .trap_en(trap_en), .trap_mode(trap_mode),
      .trap_id(trap_id), .trap_arg(trap_arg),
      .stat_word(psr_w), .mode_oh(mode_oh), .xrec_q(xrec_q)
   );

   always_comb begin
      rd_data = '0;
      if (!r_denied) begin
         case (rk)
            K_LINK:  rd_data = link_q;
            K_PC:    rd_data = pc_q[rbank];
            K_SP:    rd_data = sp_q[rbank];
            K_STAT:  rd_data = psr_w;
            K_XREC:  rd_data = xrec_q[rbank];
            default: rd_data = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) priv_viol <= 1'b0;
      else        priv_viol <= (rd_en && r_denied) || (wr_en && w_denied);
   end

   assign cur_mode = mode_oh;

endmodule

// File: rtl/mbank_sreg_file_chk.sv
module mbank_sreg_file_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_en,
   input logic [3:0]      rd_idx,
   input logic [XLEN-1:0] rd_data,
   input logic            wr_en,
   input logic [3:0]      wr_idx,
   input logic            alu_flag_we,
   input logic [3:0]      alu_flags,
   input logic            trap_en,
   input logic [1:0]      trap_mode,
   input logic [2:0]      cur_mode,
   input logic            priv_viol,
   input logic [XLEN-1:0] psr
);

   function automatic logic guarded(input logic [3:0] i);
      return (i >= 4'd5 && i <= 4'd8) || i == 4'd10 || i == 4'd11;
   endfunction

   logic bad_acc;
   assign bad_acc = cur_mode[0] && ((rd_en && guarded(rd_idx)) || (wr_en && guarded(wr_idx)));

   a_r11_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cur_mode) == 1);

   a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode[0] && rd_en && guarded(rd_idx)) |-> rd_data == '0);

   a_r8_viol_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bad_acc |=> priv_viol);

   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_acc |=> !priv_viol);

   a_r9_trap_sup: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_en && trap_mode == 2'd1) |=> cur_mode == 3'b010);

   a_r9_trap_flt: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_en && trap_mode == 2'd2) |=> cur_mode == 3'b100);

   a_r4_alu_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_flag_we && !(wr_en && wr_idx == 4'd9 && !cur_mode[0]))
      |=> psr[3:0] == $past(alu_flags));

   a_r3_user_stat_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode[0] && wr_en && wr_idx == 4'd9 && !alu_flag_we)
      |=> $stable(psr[3:0]));

endmodule

bind mbank_sreg_file mbank_sreg_file_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx[3:0]),
   .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx[3:0]),
   .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
   .trap_en(trap_en), .trap_mode(trap_mode), .cur_mode(cur_mode),
   .priv_viol(priv_viol), .psr(psr_w)
);

// File: tb/test_mbank_sreg_file.sv
module test_mbank_sreg_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        alu_flag_we = 1'b0;
   logic [3:0]  alu_flags = '0;
   logic        trap_en = 1'b0;
   logic [1:0]  trap_mode = '0;
   logic [7:0]  trap_id = '0;
   logic [23:0] trap_arg = '0;
   logic [2:0]  cur_mode;
   logic        priv_viol;

   always #4 clk = ~clk;

   mbank_sreg_file i_mbank_sreg_file (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
      .trap_en(trap_en), .trap_mode(trap_mode), .trap_id(trap_id), .trap_arg(trap_arg),
      .cur_mode(cur_mode), .priv_viol(priv_viol)
   );

   typedef struct {
      bit          rchk;
      logic [31:0] rexp;
      bit          vexp;
      string       tag;
   } exp_t;

   exp_t expq[$];
   int   checks = 0;
   int   fails  = 0;
   bit   prev_bad = 1'b0;
   bit   done = 1'b0;

   // Monitor: compares one cycle's expectations away from the clock edge.
   always @(negedge clk) begin
      if (expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         if (e.rchk) begin
            checks++;
            if (rd_data !== e.rexp) begin
               fails++;
               $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rexp);
            end
         end
         checks++;
         if (priv_viol !== e.vexp) begin
            fails++;
            $display("FAIL R8 priv_viol actual=%b expected=%b (during %s)", priv_viol, e.vexp, e.tag);
         end
      end
   end

   task automatic drive(input bit re, input logic [3:0] ri, input logic [31:0] rexp,
                        input bit we, input logic [3:0] wi, input logic [31:0] wd,
                        input bit fwe, input logic [3:0] fl,
                        input bit te, input logic [1:0] tm, input logic [7:0] tid,
                        input logic [23:0] targ, input bit bad, input string tag);
      exp_t e;
      @(posedge clk);
      #2;
      rd_en = re; rd_idx = ri;
      wr_en = we; wr_idx = wi; wr_data = wd;
      alu_flag_we = fwe; alu_flags = fl;
      trap_en = te; trap_mode = tm; trap_id = tid; trap_arg = targ;
      e.rchk = re; e.rexp = rexp; e.vexp = prev_bad; e.tag = tag;
      expq.push_back(e);
      prev_bad = bad;
   endtask

   task automatic rd(input logic [3:0] i, input logic [31:0] x, input bit bad, input string tag);
      drive(1, i, x, 0, 0, 0, 0, 0, 0, 0, 0, 0, bad, tag);
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d, input bit bad, input string tag);
      drive(0, 0, 0, 1, i, d, 0, 0, 0, 0, 0, 0, bad, tag);
   endtask

   task automatic trap(input logic [1:0] m, input logic [7:0] id, input logic [23:0] a, input string tag);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, m, id, a, 0, tag);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 12; i++)
         rd(4'(i), (i == 9) ? 32'h0000_0200 : 32'h0, 0, "R1");
      // R7 link in supervisor
      wr(4'd0, 32'h0000_1111, 0, "R7");
      rd(4'd0, 32'h0000_1111, 0, "R7");
      // R6 alias in supervisor
      wr(4'd1, 32'h0000_00A0, 0, "R6");
      rd(4'd5, 32'h0000_00A0, 0, "R6");
      rd(4'd1, 32'h0000_00A0, 0, "R6");
      wr(4'd6, 32'h0000_00B0, 0, "R6");
      rd(4'd2, 32'h0000_00B0, 0, "R6");
      // R2 masked status write
      wr(4'd9, 32'hFFFF_FFFF, 0, "R2");
      rd(4'd9, 32'h0000_020F, 0, "R2");
      wr(4'd9, 32'h0000_0005, 0, "R2");
      rd(4'd9, 32'h0000_0205, 0, "R2");
      // R10 record write ignored
      wr(4'd10, 32'hDEAD_BEEF, 0, "R10");
      rd(4'd10, 32'h0, 0, "R10");
      // R9 trap to fault
      trap(2'd2, 8'h42, 24'h123456, "R9");
      rd(4'd9, 32'h0000_0405, 0, "R9");
      rd(4'd11, 32'h4212_3456, 0, "R9");
      rd(4'd1, 32'h0, 0, "R6");
      wr(4'd2, 32'h0000_00C0, 0, "R6");
      rd(4'd8, 32'h0000_00C0, 0, "R6");
      rd(4'd6, 32'h0000_00B0, 0, "R6");
      wr(4'd11, 32'h1234_5678, 0, "R10");
      rd(4'd11, 32'h4212_3456, 0, "R10");
      // R9 return to user
      trap(2'd0, 8'hFF, 24'hFFFFFF, "R9");
      rd(4'd9, 32'h0000_0105, 0, "R9");
      rd(4'd10, 32'h0, 1, "R8");
      rd(4'd1, 32'h0, 0, "R6");
      wr(4'd1, 32'h0000_00D0, 0, "R6");
      rd(4'd3, 32'h0000_00D0, 0, "R7");
      wr(4'd4, 32'h0000_00E0, 0, "R7");
      rd(4'd2, 32'h0000_00E0, 0, "R7");
      wr(4'd0, 32'h0000_2222, 0, "R7");
      rd(4'd0, 32'h0000_2222, 0, "R7");
      // R3 user status write dropped
      wr(4'd9, 32'h0000_000A, 0, "R3");
      rd(4'd9, 32'h0000_0105, 0, "R3");
      // R8 refused accesses
      rd(4'd5, 32'h0, 1, "R8");
      rd(4'd9, 32'h0000_0105, 0, "R8");
      wr(4'd6, 32'h0000_0999, 1, "R8");
      wr(4'd7, 32'h0000_0777, 1, "R8");
      rd(4'd11, 32'h0, 1, "R8");
      trap(2'd1, 8'h07, 24'hABCDEF, "R9");
      rd(4'd6, 32'h0000_00B0, 0, "R8");
      rd(4'd7, 32'h0, 0, "R8");
      rd(4'd10, 32'h07AB_CDEF, 0, "R9");
      rd(4'd9, 32'h0000_0205, 0, "R9");
      // R4 flag port in supervisor
      drive(0, 0, 0, 0, 0, 0, 1, 4'hC, 0, 0, 0, 0, 0, "R4");
      rd(4'd9, 32'h0000_020C, 0, "R4");
      // R5 software write wins
      drive(0, 0, 0, 1, 4'd9, 32'h0000_0009, 1, 4'h6, 0, 0, 0, 0, 0, "R5");
      rd(4'd9, 32'h0000_0209, 0, "R5");
      // R4 flag port in user, R5 dropped write does not block it
      trap(2'd0, 8'h0, 24'h0, "R9");
      drive(0, 0, 0, 0, 0, 0, 1, 4'h3, 0, 0, 0, 0, 0, "R4");
      rd(4'd9, 32'h0000_0103, 0, "R4");
      drive(0, 0, 0, 1, 4'd9, 32'h0000_000F, 1, 4'h1, 0, 0, 0, 0, 0, "R5");
      rd(4'd9, 32'h0000_0101, 0, "R5");
      // R9 / R11 invalid target ignored
      trap(2'd3, 8'h55, 24'h555555, "R11");
      rd(4'd9, 32'h0000_0101, 0, "R11");
      rd(4'd11, 32'h0, 1, "R8");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      report();
   end

endmodule